// File: doc/BRIEF.md
# Counted Stepper Motor Phase Sequencer

This block controls one stepper motor channel. It drives four phase lines through one of three excitation patterns. These are full stepping with two adjacent phases energised, full stepping with a single phase energised, and half stepping, which alternates between one and two energised phases. A direction bit sets whether the pattern is walked forwards or backwards.

Software prepares a run by writing a buffer register. That register holds a 9-bit step count and a 16-bit step period. Software then writes a transfer command to the control register. The transfer copies both buffered values into the working registers, and the channel issues exactly that many steps at the programmed rate. When the last step is taken, the channel stops. It then reloads its working count from the buffer, which holds whatever value software has placed there in the meantime, and raises a sticky completion interrupt. Software clears the interrupt by writing a one to a clear bit. While the channel is idle, software can also request one step on demand. The phase lines hold their last value whenever no step is taken.

The controller is built around three named states:
- `ST_IDLE`: waiting. A transfer command moves it to `ST_RUN`, or straight to `ST_FINISH` when the buffered count is zero.
- `ST_RUN`: counting steps. When the timer expires on the last remaining step, it moves to `ST_FINISH`.
- `ST_FINISH`: lasts one cycle. It reloads the count, sets the interrupt and returns to `ST_IDLE`.

Top module: `stepper_seq`

## Requirements

Phase words below are written `phase[3:0]`, with the most significant bit first. The half-step position table for positions 0 to 7 is 1000, 1100, 0100, 0110, 0010, 0011, 0001, 1001.

- R1: After reset, `phase` is 0000, `irq` is 0, and every register reads 0. The position starts at 0, but no phase is driven until the first step.
- R2: The register map is as follows.
  - Control, address 0: bits [1:0] mode, bit 3 direction, bit 2 transfer command, bit 4 single-step command, bit 5 interrupt clear. On read it returns mode in [1:0] and direction in bit 3.
  - Buffer, address 1: bits [8:0] count, bits [31:16] period.
  - Working count, address 2: bits [8:0].
  - Address 3 reads zero.

  In `ST_IDLE`, a write with control bit 2 set copies the buffer into the working count and period and starts a run. The run issues exactly that number of steps, up to 511.
- R3: During a run, the first step comes period+1 clocks after the transfer edge, and later steps follow every period+1 clocks.
- R4: Modes 2 and 3 (half step) move one table position per step: +1 forwards, or −1 when the direction bit is set. Positions wrap modulo 8.
- R5: Mode 0 (full step, two phases on) moves to the next odd position in the chosen direction, so the outputs are 1100, 0110, 0011 and 1001.
- R6: Mode 1 (full step, one phase on) moves to the next even position in the chosen direction, so the outputs are 1000, 0100, 0010 and 0001.
- R7: With direction bit 3 set to 1, the pattern is walked in reverse order.
- R8: `irq` rises on the clock after the last step of a run. It stays high until a control write with bit 5 set, and clears on that write's edge.
- R9: The working count reads the number of steps left while a run is in progress. On completion, it is reloaded with the buffer's count at that moment.
- R10: A single-step command in `ST_IDLE` takes exactly one step on its write edge. The command is ignored during a run.
- R11: A transfer command written during a run is ignored. The run keeps its original count.
- R12: A transfer with a count of zero takes no step and still raises `irq`.
- R13: `phase` changes only on a step. A mode or direction change while idle leaves it unchanged.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock; also times the steps |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| phase | output | 4 | Phase drive lines |
| irq | output | 1 | Sticky run-completion interrupt |

## Verification

The hardest situations to reach from the ports are commands that arrive in the middle of a counted run. These include a repeated transfer, a single-step request and a buffer rewrite, together with the reload of the count at completion. The stimulus issues a transfer, waits a fixed number of clocks so that the channel is between two steps, and then writes the conflicting command. A behavioural model running in lockstep confirms that neither the step count nor the phase sequence is disturbed. A full 511-step run at the shortest period covers the count boundary, and a zero-count transfer covers the immediate completion path.

// File: rtl/stp_pkg.sv
package stp_pkg;

    localparam int NUM_PHASES = 4;
    localparam int POS_W      = 3;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_BUF  = 2'd1;
    localparam logic [1:0] ADDR_CNT  = 2'd2;

    localparam int CTRL_MODE_LSB   = 0;
    localparam int CTRL_XFER_BIT   = 2;
    localparam int CTRL_DIR_BIT    = 3;
    localparam int CTRL_SINGLE_BIT = 4;
    localparam int CTRL_CLR_BIT    = 5;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } run_state_t;

    typedef enum logic [1:0] {
        MODE_FULL2    = 2'b00,
        MODE_FULL1    = 2'b01,
        MODE_HALF     = 2'b10,
        MODE_HALF_ALT = 2'b11
    } ex_mode_t;

endpackage

// File: rtl/stp_regfile.sv
module stp_regfile
    import stp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 9,
    parameter int SPD_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    input  logic [CNT_W-1:0]  active_cnt,
    output logic [DATA_W-1:0] rd_data,
    output ex_mode_t          mode,
    output logic              dir,
    output logic [CNT_W-1:0]  buf_cnt,
    output logic [SPD_W-1:0]  buf_spd,
    output logic              cmd_xfer,
    output logic              cmd_single,
    output logic              cmd_clr
);

    localparam int SPD_LSB = DATA_W - SPD_W;

    logic [1:0] mode_q;
    logic       dir_q;
    logic       wr_ctrl;
    logic       wr_buf;
    logic       unused_bits;

    assign wr_ctrl    = wr_en && (wr_addr == ADDR_CTRL);
    assign wr_buf     = wr_en && (wr_addr == ADDR_BUF);
    assign cmd_xfer   = wr_ctrl && wr_data[CTRL_XFER_BIT];
    assign cmd_single = wr_ctrl && wr_data[CTRL_SINGLE_BIT];
    assign cmd_clr    = wr_ctrl && wr_data[CTRL_CLR_BIT];
    assign unused_bits = ^wr_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            dir_q   <= 1'b0;
            buf_cnt <= '0;
            buf_spd <= '0;
        end else begin
            if (wr_ctrl) begin
                mode_q <= wr_data[CTRL_MODE_LSB +: 2];
                dir_q  <= wr_data[CTRL_DIR_BIT];
            end
            if (wr_buf) begin
                buf_cnt <= wr_data[CNT_W-1:0];
                buf_spd <= wr_data[SPD_LSB +: SPD_W];
            end
        end
    end

    assign mode = ex_mode_t'(mode_q);
    assign dir  = dir_q;

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_CTRL: begin
                rd_data[CTRL_MODE_LSB +: 2] = mode_q;
                rd_data[CTRL_DIR_BIT]       = dir_q;
            end
            ADDR_BUF: begin
                rd_data[CNT_W-1:0]         = buf_cnt;
                rd_data[SPD_LSB +: SPD_W]  = buf_spd;
            end
            ADDR_CNT: rd_data[CNT_W-1:0]   = active_cnt;
            default:  rd_data              = '0;
        endcase
    end

endmodule

// File: rtl/stp_run_fsm.sv
module stp_run_fsm
    import stp_pkg::*;
#(
    parameter int CNT_W = 9,
    parameter int SPD_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_xfer,
    input  logic             cmd_single,
    input  logic             cmd_clr,
    input  logic [CNT_W-1:0] buf_cnt,
    input  logic [SPD_W-1:0] buf_spd,
    output logic             step,
    output logic [CNT_W-1:0] active_cnt,
    output logic             irq,
    output run_state_t       state
);

    run_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [SPD_W-1:0] spd_q;
    logic [SPD_W-1:0] timer_q;
    logic             irq_q;
    logic             tick;

    assign tick = (timer_q == '0);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_xfer)
                    state_d = (buf_cnt == '0) ? ST_FINISH : ST_RUN;
            end
            ST_RUN: begin
                if (tick && (cnt_q == CNT_W'(1)))
                    state_d = ST_FINISH;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // step request: timer expiry in a run, or an on-demand step while idle
    always_comb begin
        step = 1'b0;
        unique case (state_q)
            ST_IDLE:   step = cmd_single && !cmd_xfer;
            ST_RUN:    step = tick;
            ST_FINISH: step = 1'b0;
            default:   step = 1'b0;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            spd_q   <= '0;
            timer_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cmd_xfer) begin
                        cnt_q   <= buf_cnt;
                        spd_q   <= buf_spd;
                        timer_q <= buf_spd;
                    end
                end
                ST_RUN: begin
                    if (tick) begin
                        cnt_q   <= cnt_q - CNT_W'(1);
                        timer_q <= spd_q;
                    end else begin
                        timer_q <= timer_q - SPD_W'(1);
                    end
                end
                ST_FINISH: cnt_q <= buf_cnt;
                default: ;
            endcase
            if (state_q == ST_FINISH) irq_q <= 1'b1;
            else if (cmd_clr)         irq_q <= 1'b0;
        end
    end

    assign active_cnt = cnt_q;
    assign irq        = irq_q;
    assign state      = state_q;

endmodule

// File: rtl/stp_phase_gen.sv
module stp_phase_gen
    import stp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  step,
    input  ex_mode_t              mode,
    input  logic                  dir,
    output logic [NUM_PHASES-1:0] phase
);

    logic [POS_W-1:0]      pos_q;
    logic [POS_W-1:0]      pos_d;
    logic [POS_W-1:0]      stride;
    logic [NUM_PHASES-1:0] phase_q;
    logic                  want_odd;

    function automatic logic [NUM_PHASES-1:0] pos_to_phase(input logic [POS_W-1:0] p);
        logic [1:0]            hi;
        logic [1:0]            lo;
        logic [NUM_PHASES-1:0] v;
        hi = 2'd3 - p[2:1];
        lo = hi - 2'd1;
        v  = 4'b0001 << hi;
        if (p[0]) v = v | (4'b0001 << lo);
        return v;
    endfunction

    assign want_odd = (mode == MODE_FULL2);

    always_comb begin
        unique case (mode)
            MODE_HALF, MODE_HALF_ALT: stride = POS_W'(1);
            MODE_FULL2, MODE_FULL1:
                stride = (pos_q[0] == want_odd) ? POS_W'(2) : POS_W'(1);
            default: stride = POS_W'(1);
        endcase
        pos_d = dir ? (pos_q - stride) : (pos_q + stride);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q   <= '0;
            phase_q <= '0;
        end else if (step) begin
            pos_q   <= pos_d;
            phase_q <= pos_to_phase(pos_d);
        end
    end

    assign phase = phase_q;

endmodule

// File: rtl/stepper_seq.sv
module stepper_seq
    import stp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 9,
    parameter int SPD_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [3:0]        phase,
    output logic              irq
);

    ex_mode_t         mode_w;
    logic             dir_w;
    logic [CNT_W-1:0] buf_cnt_w;
    logic [SPD_W-1:0] buf_spd_w;
    logic             cmd_xfer_w;
    logic             cmd_single_w;
    logic             cmd_clr_w;
    logic             step_w;
    logic [CNT_W-1:0] active_cnt_w;
    run_state_t       state_w;

    stp_regfile #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SPD_W(SPD_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .active_cnt (active_cnt_w),
        .rd_data    (rd_data),
        .mode       (mode_w),
        .dir        (dir_w),
        .buf_cnt    (buf_cnt_w),
        .buf_spd    (buf_spd_w),
        .cmd_xfer   (cmd_xfer_w),
        .cmd_single (cmd_single_w),
        .cmd_clr    (cmd_clr_w)
    );

    stp_run_fsm #(.CNT_W(CNT_W), .SPD_W(SPD_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cmd_xfer   (cmd_xfer_w),
        .cmd_single (cmd_single_w),
        .cmd_clr    (cmd_clr_w),
        .buf_cnt    (buf_cnt_w),
        .buf_spd    (buf_spd_w),
        .step       (step_w),
        .active_cnt (active_cnt_w),
        .irq        (irq),
        .state      (state_w)
    );

    stp_phase_gen u_phase (
        .clk   (clk),
        .rst   (rst),
        .step  (step_w),
        .mode  (mode_w),
        .dir   (dir_w),
        .phase (phase)
    );

endmodule

// File: rtl/stepper_seq_chk.sv
module stepper_seq_chk
    import stp_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             step,
    input run_state_t       run_state,
    input logic [CNT_W-1:0] active_cnt,
    input logic [3:0]       phase,
    input logic             irq,
    input ex_mode_t         mode,
    input logic             clr
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (phase == 4'b0000) && !irq);

    assert_count_down_R2: assert property (@(posedge clk) disable iff (rst)
        (step && run_state == ST_RUN) |=> active_cnt == ($past(active_cnt) - CNT_W'(1)));

    assert_at_most_two_on_R4: assert property (@(posedge clk) disable iff (rst)
        $countones(phase) <= 2);

    assert_single_phase_on_R6: assert property (@(posedge clk) disable iff (rst)
        (step && mode == MODE_FULL1) |=> $countones(phase) == 1);

    assert_irq_after_finish_R8: assert property (@(posedge clk) disable iff (rst)
        (run_state == ST_FINISH) |=> irq);

    assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (irq && !clr) |=> irq);

    assert_hold_without_step_R13: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(phase));

endmodule

bind stepper_seq stepper_seq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .step       (step_w),
    .run_state  (state_w),
    .active_cnt (active_cnt_w),
    .phase      (phase),
    .irq        (irq),
    .mode       (mode_w),
    .clr        (cmd_clr_w)
);

// File: tb/stepper_seq_test.sv
module stepper_seq_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = 2'd2;
    logic [31:0] rd_data;
    logic [3:0]  phase;
    logic        irq;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int nchg = 0;
    int t_last = 0;
    int t_prev = 0;
    logic [3:0] prev_phase = '0;
    string cur_req = "R1";
    bit lockstep_on = 1'b0;

    // reference model state
    int m_state, m_cnt, m_spd, m_timer, m_pos, m_irq, m_mode, m_dir, m_bcnt, m_bspd;
    int m_phase;
    int o_state, o_cnt, o_timer, stride, do_step;
    bit xfer, single, clr, wr0, wr1;
    int half_tab[8] = '{8, 12, 4, 6, 2, 3, 1, 9};

    stepper_seq uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .phase(phase), .irq(irq)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural model, advanced on every rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_state = 0; m_cnt = 0; m_spd = 0; m_timer = 0; m_pos = 0; m_irq = 0;
            m_mode = 0; m_dir = 0; m_bcnt = 0; m_bspd = 0; m_phase = 0;
        end else begin
            wr0 = wr_en && wr_addr == 2'd0;
            wr1 = wr_en && wr_addr == 2'd1;
            xfer = wr0 && wr_data[2];
            single = wr0 && wr_data[4];
            clr = wr0 && wr_data[5];
            o_state = m_state; o_cnt = m_cnt; o_timer = m_timer;
            do_step = 0;
            if (o_state == 0) begin
                if (xfer) begin
                    m_cnt = m_bcnt; m_spd = m_bspd; m_timer = m_bspd;
                    m_state = (m_bcnt == 0) ? 2 : 1;
                end else if (single) do_step = 1;
            end else if (o_state == 1) begin
                if (o_timer == 0) begin
                    do_step = 1; m_cnt = o_cnt - 1; m_timer = m_spd;
                    if (o_cnt == 1) m_state = 2;
                end else m_timer = o_timer - 1;
            end else begin
                m_cnt = m_bcnt; m_state = 0;
            end
            if (o_state == 2) m_irq = 1;
            else if (clr) m_irq = 0;
            if (do_step != 0) begin
                if (m_mode >= 2) stride = 1;
                else if (m_mode == 0) stride = (m_pos % 2 == 1) ? 2 : 1;
                else stride = (m_pos % 2 == 0) ? 2 : 1;
                m_pos = m_dir != 0 ? (m_pos - stride + 8) % 8 : (m_pos + stride) % 8;
                m_phase = half_tab[m_pos];
            end
            if (wr0) begin m_mode = wr_data[1:0]; m_dir = wr_data[3]; end
            if (wr1) begin m_bcnt = wr_data[8:0]; m_bspd = wr_data[31:16]; end
        end
    end

    function automatic int exp_rd(input logic [1:0] a);
        case (a)
            2'd0: return m_mode | (m_dir << 3);
            2'd1: return m_bcnt | (m_bspd << 16);
            2'd2: return m_cnt;
            default: return 0;
        endcase
    endfunction

    // lockstep comparison and step monitor
    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            if (phase != prev_phase) begin
                nchg++; t_prev = t_last; t_last = cyc;
            end
            prev_phase = phase;
            if (lockstep_on) begin
                chk({cur_req, " phase"}, phase, m_phase);
                chk({cur_req, " irq"}, irq, m_irq);
                chk({cur_req, " rd_data"}, rd_data, exp_rd(rd_addr));
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    function automatic logic [31:0] ctrl(input int mode, input int dir, input int xf,
                                         input int sg, input int cl);
        return 32'(mode) | 32'(xf << 2) | 32'(dir << 3) | 32'(sg << 4) | 32'(cl << 5);
    endfunction

    function automatic logic [31:0] bufv(input int cnt, input int spd);
        return 32'(cnt) | (32'(spd) << 16);
    endfunction

    task automatic wait_irq(input int limit);
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (irq) break;
        end
    endtask

    task automatic start_run(input int mode, input int dir, input int cnt, input int spd);
        wr(2'd1, bufv(cnt, spd));
        nchg = 0;
        wr(2'd0, ctrl(mode, dir, 1, 0, 0));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 phase", phase, 0);
        chk("R1 irq", irq, 0);
        chk("R1 count", rd_data, 0);
        lockstep_on = 1'b1;

        // R2 R3 R4 R9: half step forward, 5 steps, period 4; buffer rewritten mid-run
        cur_req = "R4";
        start_run(2, 0, 5, 3);
        repeat (6) @(negedge clk);
        wr(2'd1, bufv(7, 3));
        wait_irq(200);
        chk("R2 steps", nchg, 5);
        chk("R3 interval", t_last - t_prev, 4);
        chk("R4 final phase", phase, 4'b0011);
        @(negedge clk);
        chk("R9 reload count", rd_data, 7);

        // R8 sticky then clear
        cur_req = "R8";
        repeat (10) @(negedge clk);
        chk("R8 sticky", irq, 1);
        wr(2'd0, ctrl(2, 0, 0, 0, 1));
        @(negedge clk);
        chk("R8 cleared", irq, 0);

        // R13 mode change idle holds phase
        cur_req = "R13";
        wr(2'd0, ctrl(1, 0, 0, 0, 0));
        repeat (3) @(negedge clk);
        chk("R13 hold", phase, 4'b0011);

        // R6 one-phase full step, period 1
        cur_req = "R6";
        start_run(1, 0, 2, 0);
        wait_irq(50);
        chk("R6 steps", nchg, 2);
        chk("R3 interval min", t_last - t_prev, 1);
        chk("R6 final phase", phase, 4'b1000);
        wr(2'd0, ctrl(1, 0, 0, 0, 1));

        // R5 R7 two-phase reverse
        cur_req = "R7";
        start_run(0, 1, 3, 1);
        wait_irq(50);
        chk("R5 steps", nchg, 3);
        chk("R7 reverse final phase", phase, 4'b0110);
        wr(2'd0, ctrl(0, 1, 0, 0, 1));

        // R10 single step idle, ignored during a run
        cur_req = "R10";
        wr(2'd0, ctrl(2, 0, 0, 0, 0));
        wr(2'd0, ctrl(2, 0, 0, 1, 0));
        @(negedge clk);
        chk("R10 single step", phase, 4'b0010);
        start_run(2, 0, 4, 5);
        repeat (3) @(negedge clk);
        wr(2'd0, ctrl(2, 0, 0, 1, 0));
        wait_irq(100);
        chk("R10 steps in run", nchg, 4);
        chk("R10 final phase", phase, 4'b1000);
        wr(2'd0, ctrl(2, 0, 0, 0, 1));

        // R11 transfer during run ignored
        cur_req = "R11";
        start_run(2, 0, 3, 2);
        repeat (2) @(negedge clk);
        wr(2'd1, bufv(9, 2));
        wr(2'd0, ctrl(2, 0, 1, 0, 0));
        wait_irq(100);
        chk("R11 steps", nchg, 3);
        @(negedge clk);
        chk("R9 reload after run", rd_data, 9);
        wr(2'd0, ctrl(2, 0, 0, 0, 1));

        // R12 zero count
        cur_req = "R12";
        start_run(2, 0, 0, 4);
        wait_irq(20);
        chk("R12 irq", irq, 1);
        chk("R12 no step", nchg, 0);
        wr(2'd0, ctrl(2, 0, 0, 0, 1));

        // R2 maximum count 511 at period 1
        cur_req = "R2";
        start_run(2, 0, 511, 0);
        wait_irq(2000);
        chk("R2 max steps", nchg, 511);
        chk("R2 max final phase", phase, 4'b0100);

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule